// File: doc/BRIEF.md
# Serial EEPROM Command and Write-Protection Core

This block is the command and write-control core of a byte-wide serial EEPROM model with 8192 bytes of storage. A serial front end hands it whole received bytes together with a frame-start strobe (select asserted) and a frame-end strobe (select released). The core decodes the first byte of each frame as an opcode. It keeps a small status register and collects write data into a one-page buffer. When a frame that completed a valid write sequence ends, it runs a self-timed internal write cycle. It also presents the byte that the front end must shift out in the next byte slot.

The storage array sits outside the block. The core drives a write port that commits the page buffer one byte per clock at the start of the write cycle. It also drives a combinational read address whose data comes straight back. Writes are gated in three ways: by a write-enable latch, by a two-bit block-protect field covering none, the upper quarter, the upper half or all of the array, and by the external write-protect input. That input is honoured only when the protect-enable bit in the status register is set. The write cycle length is the parameter `WR_CYCLES`, so simulation can shorten the 5 ms cycle.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and `tx_byte` is 0x00.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it; opcode 0x05 makes `tx_byte` show the status byte for the rest of the frame.
- R3: An array write (opcode 0x02) or status write (opcode 0x01) sent while the write-enable latch is clear changes nothing and starts no cycle.
- R4: A valid write sequence starts the internal cycle only at its frame end. Status bit 0 then reads 1 for `WR_CYCLES` clocks and then returns to 0. The write-enable latch is cleared when the cycle finishes.
- R5: Opcode 0x02 takes a 16-bit address, high byte first, followed by data. Bytes that run past the end of a 32-byte page wrap to the start of the same page.
- R6: Block-protect field in status bits 3:2: 00 protects nothing, 01 protects 0x1800–0x1FFF, 10 protects 0x1000–0x1FFF, 11 protects everything. An array write aimed at a protected page is discarded and starts no cycle.
- R7: When status bit 7 (protect enable) is 1 and `wp_n` is low, a status write is refused while array writes still work. When bit 7 is 0, `wp_n` has no effect.
- R8: While a cycle is in progress, every opcode except 0x05 is ignored. A read then returns 0x00 and 0x04 leaves the latch set.
- R9: Opcode 0x03 takes a 16-bit address whose top 3 bits are ignored. It returns sequential bytes that wrap from 0x1FFF to 0x0000.
- R10: Only the bytes actually sent in a write sequence are changed in the array; the rest of the page keeps its contents.
- R11: A status write stores only bits 7, 3 and 2 of its data byte. Bits 6:4 read 0, and bits 1:0 always show the latch and busy flags.
- R12: A write frame that ends before any data byte arrives starts no cycle and leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| frame_start | input | 1 | One-cycle strobe: select asserted, a new frame begins |
| frame_end | input | 1 | One-cycle strobe: select released, frame ends |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| wp_n | input | 1 | External write-protect input, active low |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| mem_raddr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data for `mem_raddr`, combinational |

## Verification
The write-enable latch, the protect fields and the busy flag can all be seen in the status byte. A wrong value in any of them shows at the next status read, one byte slot after the opcode. A wrong page-buffer offset or a stale buffer mask shows only when the array is read back, as changed neighbours or missing bytes within the page, once the cycle has ended. A wrong cycle counter shows as a busy flag that clears too early or never clears. So the bench polls the status during the cycle as well as after it.

// File: rtl/eeprom_ctl_pkg.sv
package eeprom_ctl_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_OPC  = 3'd0,
    PH_ADRH = 3'd1,
    PH_ADRL = 3'd2,
    PH_DATA = 3'd3,
    PH_SKIP = 3'd4
  } phase_e;
endpackage

// File: rtl/ee_protect.sv
module ee_protect #(
  parameter int ADDR_W = 13
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              blocked
);
  always_comb begin
    unique case (bp)
      2'b00:   blocked = 1'b0;
      2'b01:   blocked = addr[ADDR_W-1] & addr[ADDR_W-2];
      2'b10:   blocked = addr[ADDR_W-1];
      default: blocked = 1'b1;
    endcase
  end
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             rd_mask,
  output logic             any
);
  logic [7:0]            store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr)        mask_d = '0;
    else if (wr_en) mask_d[wr_off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_off] <= wr_data;
  end

  assign rd_data = store[rd_off];
  assign rd_mask = mask_q[rd_off];
  assign any     = |mask_q;
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int WR_CYCLES = 1250000,
  localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);
  logic             busy_d;
  logic [CNT_W-1:0] cnt_d;

  assign done = busy && (cnt == LAST);

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy) begin
      cnt_d = cnt + 1'b1;
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= busy_d;
      cnt  <= cnt_d;
    end
  end
endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl
  import eeprom_ctl_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              wp_n,
  output logic [7:0]        tx_byte,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int HI_W  = ADDR_W - 8;

  phase_e             phase_q, phase_d;
  logic [7:0]         op_q, op_d, stage_q, stage_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [PG_W-1:0]    cpage_q, cpage_d;
  logic               wel_q, wel_d, wpen_q, wpen_d, have_sr_q, have_sr_d;
  logic               arr_q, arr_d;
  logic [1:0]         bp_q, bp_d;
  logic               start, busy, done, blocked;
  logic [CNT_W-1:0]   cnt;
  logic               buf_wr, buf_clr, buf_mask, buf_any;
  logic [7:0]         buf_rdata;
  logic               can_write, arr_ok, sr_ok;

  ee_protect #(.ADDR_W(ADDR_W)) u_prot (.bp(bp_q), .addr(addr_q), .blocked(blocked));

  ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_off(addr_q[OFF_W-1:0]), .wr_data(rx_byte), .rd_off(cnt[OFF_W-1:0]),
    .rd_data(buf_rdata), .rd_mask(buf_mask), .any(buf_any));

  ee_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cnt(cnt), .done(done));

  assign can_write = wel_q && !busy && (phase_q == PH_DATA);
  assign arr_ok    = can_write && (op_q == OP_WRITE) && buf_any && !blocked;
  assign sr_ok     = can_write && (op_q == OP_WRSR) && have_sr_q && !(wpen_q && !wp_n);
  assign buf_clr   = (frame_start && !busy) || done;

  always_comb begin
    phase_d   = phase_q;
    op_d      = op_q;
    addr_d    = addr_q;
    stage_d   = stage_q;
    have_sr_d = have_sr_q;
    wel_d     = wel_q;
    bp_d      = bp_q;
    wpen_d    = wpen_q;
    cpage_d   = cpage_q;
    arr_d     = arr_q;
    start     = 1'b0;
    buf_wr    = 1'b0;
    if (frame_start) begin
      phase_d   = PH_OPC;
      have_sr_d = 1'b0;
    end else if (frame_end) begin
      phase_d = PH_SKIP;
      if (arr_ok) begin
        start   = 1'b1;
        arr_d   = 1'b1;
        cpage_d = addr_q[ADDR_W-1:OFF_W];
      end else if (sr_ok) begin
        start  = 1'b1;
        arr_d  = 1'b0;
        bp_d   = stage_q[3:2];
        wpen_d = stage_q[7];
      end
    end else if (rx_valid) begin
      unique case (phase_q)
        PH_OPC: begin
          op_d    = rx_byte;
          phase_d = PH_SKIP;
          if (!busy || rx_byte == OP_RDSR) begin
            unique case (rx_byte)
              OP_WREN:            wel_d   = 1'b1;
              OP_WRDI:            wel_d   = 1'b0;
              OP_RDSR, OP_WRSR:   phase_d = PH_DATA;
              OP_READ, OP_WRITE:  phase_d = PH_ADRH;
              default:            phase_d = PH_SKIP;
            endcase
          end
        end
        PH_ADRH: begin
          addr_d[ADDR_W-1:8] = rx_byte[HI_W-1:0];
          phase_d = PH_ADRL;
        end
        PH_ADRL: begin
          addr_d[7:0] = rx_byte;
          phase_d = PH_DATA;
        end
        PH_DATA: begin
          if (op_q == OP_WRITE) begin
            buf_wr = 1'b1;
            addr_d[OFF_W-1:0] = addr_q[OFF_W-1:0] + 1'b1;
          end else if (op_q == OP_READ) begin
            addr_d = addr_q + 1'b1;
          end else if (op_q == OP_WRSR && !have_sr_q) begin
            stage_d   = rx_byte;
            have_sr_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (done) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_SKIP;
      op_q      <= '0;
      addr_q    <= '0;
      stage_q   <= '0;
      have_sr_q <= 1'b0;
      wel_q     <= 1'b0;
      bp_q      <= 2'b00;
      wpen_q    <= 1'b0;
      cpage_q   <= '0;
      arr_q     <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      op_q      <= op_d;
      addr_q    <= addr_d;
      stage_q   <= stage_d;
      have_sr_q <= have_sr_d;
      wel_q     <= wel_d;
      bp_q      <= bp_d;
      wpen_q    <= wpen_d;
      cpage_q   <= cpage_d;
      arr_q     <= arr_d;
    end
  end

  assign mem_we    = busy && arr_q && (cnt < CNT_W'(PAGE_BYTES)) && buf_mask;
  assign mem_waddr = {cpage_q, cnt[OFF_W-1:0]};
  assign mem_wdata = buf_rdata;
  assign mem_raddr = addr_q;

  always_comb begin
    tx_byte = 8'h00;
    if (phase_q == PH_DATA) begin
      if (op_q == OP_RDSR)      tx_byte = {wpen_q, 3'b000, bp_q, wel_q, busy};
      else if (op_q == OP_READ) tx_byte = mem_rdata;
    end
  end
endmodule

// File: rtl/eeprom_wr_ctrl_chk.sv
module eeprom_wr_ctrl_chk #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 1250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_end,
  input logic              busy,
  input logic              wel,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [1:0]        bp
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  int unsigned run_len;

  function automatic logic in_guard(input logic [1:0] f, input logic [ADDR_W-1:0] a);
    logic [1:0] top;
    top = a[ADDR_W-1 -: 2];
    return (f == 2'b11) || (f == 2'b10 && top >= 2'b10) || (f == 2'b01 && top == 2'b11);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R4
  busy_start_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_end));
  // R4
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < WR_CYCLES));
  // R4
  wel_clear_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R8
  write_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R6
  no_protected_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_guard(bp, mem_waddr));
  // R5
  single_page_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_waddr[ADDR_W-1:OFF_W] == $past(mem_waddr[ADDR_W-1:OFF_W])));
endmodule

bind eeprom_wr_ctrl eeprom_wr_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .busy(busy), .wel(wel_q),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .bp(bp_q)
);

// File: tb/eeprom_wr_ctrl_tb.sv
module eeprom_wr_ctrl_tb;
  localparam int WRC = 100;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, frame_end = 1'b0, rx_valid = 1'b0, wp_n = 1'b1;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] tx_byte, mem_wdata, mem_rdata;
  logic mem_we;
  logic [12:0] mem_waddr, mem_raddr;
  logic [7:0] mem [0:8191];
  logic [7:0] exp_mem [0:8191];
  logic [7:0] wbuf [0:31];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eeprom_wr_ctrl #(.ADDR_W(13), .PAGE_BYTES(32), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .wp_n(wp_n), .tx_byte(tx_byte),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata));

  always @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;
  assign mem_rdata = mem[mem_raddr];

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic fs();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask
  task automatic fe();
    @(negedge clk) frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
  endtask
  task automatic sb(input logic [7:0] b, output logic [7:0] t);
    @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
    @(negedge clk) rx_valid = 1'b0;
    t = tx_byte;
  endtask
  task automatic cmd(input logic [7:0] op);
    logic [7:0] t;
    fs(); sb(op, t); fe();
  endtask
  task automatic rdsr(output logic [7:0] s);
    fs(); sb(8'h05, s); fe();
  endtask
  task automatic wait_idle();
    logic [7:0] s;
    int k = 0;
    rdsr(s);
    while (s[0] && k < 60) begin rdsr(s); k++; end
    chk("R4 busy clears", {7'b0, s[0]}, 8'h00);
  endtask
  task automatic wrsr(input logic [7:0] v);
    logic [7:0] t;
    fs(); sb(8'h01, t); sb(v, t); fe();
  endtask
  task automatic wr(input logic [15:0] a, input int n, input bit ok);
    logic [7:0] t;
    fs(); sb(8'h02, t); sb(a[15:8], t); sb(a[7:0], t);
    for (int i = 0; i < n; i++) sb(wbuf[i], t);
    fe();
    if (ok)
      for (int i = 0; i < n; i++)
        exp_mem[(int'(a) & 32'h1FE0) | ((int'(a) + i) & 31)] = wbuf[i];
  endtask
  task automatic read_chk(input logic [15:0] a, input int n, input string r);
    logic [7:0] t;
    int p;
    fs(); sb(8'h03, t); sb(a[15:8], t); sb(a[7:0], t);
    p = int'(a) & 32'h1FFF;
    for (int i = 0; i < n; i++) begin
      if (i > 0) sb(8'h00, t);
      chk(r, t, exp_mem[p]);
      p = (p + 1) % 8192;
    end
    fe();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    logic [7:0] s, t;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8192; i++) begin
      mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
      exp_mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx after reset", tx_byte, 8'h00);
    rdsr(s); chk("R1 status after reset", s, 8'h00);

    // R3: no latch, write ignored
    wbuf[0] = 8'hAA;
    wr(16'h0100, 1, 0);
    rdsr(s); chk("R3 no cycle", s, 8'h00);
    read_chk(16'h0100, 1, "R3 array unchanged");
    fs(); sb(8'h01, t); sb(8'h0C, t); fe();
    rdsr(s); chk("R3 status write ignored", s, 8'h00);

    // R2
    cmd(8'h06); rdsr(s); chk("R2 latch set", s, 8'h02);
    cmd(8'h04); rdsr(s); chk("R2 latch cleared", s, 8'h00);

    // R4: cycle timing
    cmd(8'h06);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr(16'h0100, 3, 1);
    rdsr(s); chk("R4 busy after end", s, 8'h03);
    repeat (WRC - 40) @(negedge clk);
    rdsr(s); chk("R4 still busy", s, 8'h03);
    wait_idle();
    rdsr(s); chk("R4 latch cleared at done", s, 8'h00);
    read_chk(16'h00FE, 6, "R4 data committed");

    // R12: no data byte
    cmd(8'h06);
    wr(16'h0200, 0, 0);
    rdsr(s); chk("R12 no cycle, latch kept", s, 8'h02);

    // R5: page wrap
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hC0 + 8'(i);
    wr(16'h003E, 4, 1);
    wait_idle();
    read_chk(16'h0020, 32, "R5 page wrap");

    // R8: busy ignores other opcodes
    cmd(8'h06);
    wbuf[0] = 8'h5A;
    wr(16'h0200, 1, 1);
    fs(); sb(8'h03, t); sb(8'h00, t); sb(8'h00, t); chk("R8 read ignored while busy", t, 8'h00); fe();
    cmd(8'h04);
    rdsr(s); chk("R8 disable ignored while busy", s, 8'h03);
    wait_idle();
    read_chk(16'h0200, 1, "R8 write completed");

    // R6 / R11
    cmd(8'h06); wrsr(8'h04);
    rdsr(s); chk("R11 status applied at start", s, 8'h07);
    wait_idle();
    rdsr(s); chk("R6 quarter field", s, 8'h04);
    cmd(8'h06); wbuf[0] = 8'hEE;
    wr(16'h1800, 1, 0);
    rdsr(s); chk("R6 quarter refused", s, 8'h06);
    read_chk(16'h1800, 1, "R6 quarter unchanged");
    wr(16'h17E0, 1, 1); wait_idle();
    read_chk(16'h17E0, 1, "R6 below quarter written");
    cmd(8'h06); wrsr(8'h08); wait_idle();
    cmd(8'h06); wr(16'h1000, 1, 0);
    rdsr(s); chk("R6 half refused", s, 8'h0A);
    wr(16'h0FE0, 1, 1); wait_idle();
    read_chk(16'h1000, 1, "R6 half unchanged");
    read_chk(16'h0FE0, 1, "R6 below half written");
    cmd(8'h06); wrsr(8'h0C); wait_idle();
    cmd(8'h06); wr(16'h0000, 1, 0);
    rdsr(s); chk("R6 all refused", s, 8'h0E);
    read_chk(16'h0000, 1, "R6 all unchanged");
    wrsr(8'h73); wait_idle();
    rdsr(s); chk("R11 only bits 7,3,2 stored", s, 8'h00);

    // R7
    wp_n = 1'b0;
    cmd(8'h06); wrsr(8'h80); wait_idle();
    rdsr(s); chk("R7 pin ignored when enable clear", s, 8'h80);
    cmd(8'h06); wrsr(8'h84);
    rdsr(s); chk("R7 status write refused", s, 8'h82);
    wbuf[0] = 8'h9C;
    wr(16'h0300, 1, 1); wait_idle();
    read_chk(16'h0300, 1, "R7 array write unaffected");
    wp_n = 1'b1;
    cmd(8'h06); wrsr(8'h04); wait_idle();
    rdsr(s); chk("R7 status write with pin high", s, 8'h04);
    cmd(8'h06); wrsr(8'h00); wait_idle();

    // R9
    read_chk(16'h1FFE, 4, "R9 read wrap");
    read_chk(16'hFFFE, 3, "R9 top address bits ignored");

    // R10: random writes against the model
    cmd(8'h04);
    for (int it = 0; it < 30; it++) begin
      logic [15:0] a;
      int n;
      bit ok;
      a  = 16'($urandom % 65536);
      n  = 1 + int'($urandom % 32);
      ok = ($urandom % 5) != 0;
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      if (ok) cmd(8'h06);
      wr(a, n, ok);
      wait_idle();
      read_chk(a & 16'h1FE0, 32, "R10 page contents");
    end
    report();
  end
endmodule